// File: doc/BRIEF.md
# Byte-Lane Pipelined Burst Memory Datapath

This block is the storage and data path of a small synchronous memory whose words are split into byte lanes of nine bits (eight data bits and one parity bit). Each clock it takes one command from an external burst sequencer: a select, an address, the write controls and the write data. It decides which lanes to write and stores them. A read returns its word on the data-out bus two rising edges after the command is sampled.

The bus is modelled as a data vector and a drive-enable bit. The drive-enable follows the active-low output-enable pin without waiting for a clock. It is forced low in the cycle after a write is sampled, when no read is in flight, and while the block sleeps.

A power-down input puts the block to sleep after a fixed entry window. Sleep keeps the array contents intact. Accesses are refused until a recovery window has passed after the input is released. Writes are staged for one cycle before they reach the array. A read that comes straight after a write therefore merges the staged lanes into its result, so it never returns stale data.

Top module: `bytelane_burst_mem`

## Requirements
- R1: A command with `sel` high and `wr_all_n` low writes every lane of the addressed word, whatever `wr_byte_n` and `lane_sel_n` are.
- R2: With `wr_all_n` high and `wr_byte_n` low, lane i is written when `lane_sel_n[i]` is 0. If every bit of `lane_sel_n` is 1, the command is a read.
- R3: With both `wr_all_n` and `wr_byte_n` high, the command is a read and the array is unchanged.
- R4: Lane i occupies bits [9i+8:9i] of `wdata` and `dout`, and bit 9i+8 is that lane's parity bit. The default configuration has four lanes (36 bits).
- R5: A read accepted at rising edge n puts the addressed word on `dout` after edge n+1. `dout_en` is then 1 if `out_en_n` is 0, no write was accepted at edge n+1, and the block is awake.
- R6: `dout_en` is 0 in the cycle after any edge that accepts a write, whatever `out_en_n` is. Otherwise `out_en_n` high forces `dout_en` to 0 at once, without waiting for a clock.
- R7: A read accepted at the edge right after a write to the same address returns the newly written lanes merged with the old contents of the unwritten lanes.
- R8: If `sleep_req` is sampled high at edge n while the block is running, accesses at edges n, n+1 and n+2 are still performed. From edge n+3 on, accesses are ignored and `dout_en` is 0.
- R9: A cycle with `sel` low performs no access, even with write controls asserted. Two edges after such a cycle, `dout_en` is 0.
- R10: If `sleep_req` is sampled low at edge m while asleep, accesses at edges m, m+1 and m+2 are ignored. The first access accepted is at edge m+3.
- R11: Array contents written before sleep are unchanged after wake-up. Writes offered while asleep or recovering have no effect.
- R12: While `rst` is high and after its release, `dout_en` is 0 until a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Command present this cycle (chip selected) |
| addr | input | $clog2(DEPTH) | Word address from the burst sequencer |
| wr_all_n | input | 1 | Active-low write of all lanes |
| wr_byte_n | input | 1 | Active-low qualifier for per-lane writes |
| lane_sel_n | input | LANES | Active-low per-lane write enables |
| wdata | input | LANES*9 | Write data, nine bits per lane |
| out_en_n | input | 1 | Active-low output enable, asynchronous |
| sleep_req | input | 1 | Power-down request, active high |
| dout | output | LANES*9 | Registered read data |
| dout_en | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The assertions assume that `addr` stays below DEPTH and that the command inputs are known whenever `sel` is high. They also assume that reset is held for at least two edges, so that the power state has a defined history. The bench meets these conditions by using a sixteen-word configuration, driving every input only at falling edges, and starting from a three-cycle reset. It changes `out_en_n` mid-cycle only to probe the asynchronous enable, and it moves `sleep_req` only at falling edges. This keeps the entry and recovery windows aligned to known edges.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int unsigned LANE_BITS = 9;

  typedef enum logic [1:0] {
    P_RUN   = 2'd0,
    P_ENT   = 2'd1,
    P_SLEEP = 2'd2,
    P_WAKE  = 2'd3
  } pwr_state_t;

  function automatic logic pwr_live(input pwr_state_t s);
    return (s == P_RUN) || (s == P_ENT);
  endfunction
endpackage

// File: rtl/bwm_wdec.sv
module bwm_wdec #(
  parameter int unsigned LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_mask,
  output logic             is_write
);
  always_comb begin
    if (!wr_all_n)       lane_mask = '1;
    else if (!wr_byte_n) lane_mask = ~lane_sel_n;
    else                 lane_mask = '0;
    is_write = |lane_mask;
  end
endmodule

// File: rtl/bwm_lane_ram.sv
module bwm_lane_ram #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-first simple dual port, one lane wide
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/bwm_pwr.sv
module bwm_pwr
  import bwm_pkg::*;
#(
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned WAKE_CYC  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  output logic live
);
  localparam int unsigned MAXC = (ENTER_CYC > WAKE_CYC) ? ENTER_CYC : WAKE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  pwr_state_t    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= P_RUN;
      cnt_q <= '0;
    end else begin
      case (st_q)
        P_RUN: if (sleep_req) begin
          st_q  <= P_ENT;
          cnt_q <= '0;
        end
        P_ENT: if (cnt_q == CW'(ENTER_CYC - 1)) begin
          st_q  <= P_SLEEP;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        P_SLEEP: if (!sleep_req) begin
          st_q  <= P_WAKE;
          cnt_q <= '0;
        end
        P_WAKE: if (cnt_q == CW'(WAKE_CYC - 1)) begin
          st_q  <= P_RUN;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= P_RUN;
      endcase
    end
  end

  assign live = pwr_live(st_q);

  // R8: a request while running starts the entry window
  p_enter_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_RUN && sleep_req) |=> (st_q == P_ENT));
  // R8: sleep is reached only through the entry window
  p_sleep_src_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_SLEEP) |-> ($past(st_q) == P_ENT || $past(st_q) == P_SLEEP));
  // R10: release while asleep starts recovery
  p_wake_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_SLEEP && !sleep_req) |=> (st_q == P_WAKE));
  // R10: never straight from sleep back to running
  p_run_src_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == P_RUN) |-> ($past(st_q) != P_SLEEP));
endmodule

// File: rtl/bwm_rdpipe.sv
module bwm_rdpipe #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_issue,
  input  logic                    hit,
  input  logic [LANES*LANE_W-1:0] byp_data,
  input  logic [LANES-1:0]        byp_mask,
  input  logic [LANES*LANE_W-1:0] ram_q,
  output logic [LANES*LANE_W-1:0] out_q,
  output logic                    v_out
);
  localparam int unsigned W = LANES * LANE_W;

  logic             v1_q, hit1_q;
  logic [W-1:0]     byp1_q, merged;
  logic [LANES-1:0] msk1_q;

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (hit1_q && msk1_q[l]) ?
      byp1_q[l*LANE_W +: LANE_W] : ram_q[l*LANE_W +: LANE_W];

    // R7: a staged lane overrides the stale array word
    p_bypass_r7: assert property (@(posedge clk) disable iff (rst)
      (v1_q && hit1_q && msk1_q[l]) |=>
        (out_q[l*LANE_W +: LANE_W] == $past(byp1_q[l*LANE_W +: LANE_W])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q   <= 1'b0;
      hit1_q <= 1'b0;
      v_out  <= 1'b0;
      out_q  <= '0;
      byp1_q <= '0;
      msk1_q <= '0;
    end else begin
      v1_q   <= rd_issue;
      hit1_q <= rd_issue & hit;
      byp1_q <= byp_data;
      msk1_q <= byp_mask;
      v_out  <= v1_q;
      if (v1_q) out_q <= merged;
    end
  end

  // R5: a read reaches the output stage two edges later
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    rd_issue |-> ##2 v_out);
endmodule

// File: rtl/bytelane_burst_mem.sv
module bytelane_burst_mem #(
  parameter int unsigned LANES     = 4,
  parameter int unsigned LANE_W    = bwm_pkg::LANE_BITS,
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned WAKE_CYC  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel,
  input  logic [$clog2(DEPTH)-1:0]  addr,
  input  logic                      wr_all_n,
  input  logic                      wr_byte_n,
  input  logic [LANES-1:0]          lane_sel_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      out_en_n,
  input  logic                      sleep_req,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_en
);
  localparam int unsigned W  = LANES * LANE_W;
  localparam int unsigned AW = $clog2(DEPTH);

  logic             live, is_write, acc, wr_go, rd_go, hit, blank_q, v_out;
  logic [LANES-1:0] lane_mask, wb_mask_q;
  logic             wb_v_q;
  logic [AW-1:0]    wb_addr_q;
  logic [W-1:0]     wb_data_q, ram_q, out_q;

  bwm_wdec #(.LANES(LANES)) u_wdec (
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_sel_n(lane_sel_n),
    .lane_mask (lane_mask),
    .is_write  (is_write)
  );

  bwm_pwr #(.ENTER_CYC(ENTER_CYC), .WAKE_CYC(WAKE_CYC)) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .sleep_req(sleep_req),
    .live     (live)
  );

  assign acc   = sel & live;
  assign wr_go = acc & is_write;
  assign rd_go = acc & ~is_write;

  // one-deep write staging register ahead of the array
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_v_q    <= 1'b0;
      wb_addr_q <= '0;
      wb_data_q <= '0;
      wb_mask_q <= '0;
      blank_q   <= 1'b0;
    end else begin
      wb_v_q  <= wr_go;
      blank_q <= wr_go;
      if (wr_go) begin
        wb_addr_q <= addr;
        wb_data_q <= wdata;
        wb_mask_q <= lane_mask;
      end
    end
  end

  assign hit = wb_v_q && (wb_addr_q == addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bwm_lane_ram #(.WIDTH(LANE_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .clk  (clk),
      .we   (wb_v_q & wb_mask_q[l]),
      .waddr(wb_addr_q),
      .wdata(wb_data_q[l*LANE_W +: LANE_W]),
      .re   (rd_go),
      .raddr(addr),
      .rdata(ram_q[l*LANE_W +: LANE_W])
    );
  end

  bwm_rdpipe #(.LANES(LANES), .LANE_W(LANE_W)) u_rdpipe (
    .clk     (clk),
    .rst     (rst),
    .rd_issue(rd_go),
    .hit     (hit),
    .byp_data(wb_data_q),
    .byp_mask(wb_mask_q),
    .ram_q   (ram_q),
    .out_q   (out_q),
    .v_out   (v_out)
  );

  assign dout    = out_q;
  assign dout_en = v_out & ~blank_q & ~out_en_n & live;

  // R6: an accepted write releases the bus for the next cycle
  p_wr_blank_r6: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> !dout_en);
  // R9: a deselected cycle leaves the bus released two edges later
  p_deselect_r9: assert property (@(posedge clk) disable iff (rst)
    !sel |-> ##2 !dout_en);
  // R11: nothing is staged for the array while asleep or recovering
  p_sleep_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (!live && sel) |=> !wb_v_q);
endmodule

// File: tb/tb_bytelane_burst_mem.sv
module tb_bytelane_burst_mem;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int LW    = 9;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int W     = LANES * LW;

  logic clk = 1'b0, rst = 1'b1, sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [LANES-1:0] lane_sel_n = '1;
  logic [W-1:0] wdata = '0;
  logic out_en_n = 1'b0, sleep_req = 1'b0;
  logic [W-1:0] dout;
  logic dout_en;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [W-1:0] ref_mem [DEPTH];
  logic prev_rd_v = 1'b0;
  logic [W-1:0] prev_rd_d = '0;

  bytelane_burst_mem #(.LANES(LANES), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .sel(sel), .addr(addr), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n), .wdata(wdata),
    .out_en_n(out_en_n), .sleep_req(sleep_req), .dout(dout), .dout_en(dout_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'(64'(i) * 64'h0000_0009_E377_9B97 + 64'h5A5);
  endfunction

  function automatic logic [LANES-1:0] exp_mask(input logic wa, input logic wb, input logic [LANES-1:0] ls);
    if (!wa) return '1;
    if (!wb) return ~ls;
    return '0;
  endfunction

  task automatic step(input string tag, input logic s, input logic [AW-1:0] a, input logic wa,
                      input logic wb, input logic [LANES-1:0] ls, input logic [W-1:0] d,
                      input bit acc, input bit awk);
    logic [LANES-1:0] m;
    bit cw, cr, ee;
    logic [W-1:0] ed;
    sel = s; addr = a; wr_all_n = wa; wr_byte_n = wb; lane_sel_n = ls; wdata = d;
    @(posedge clk);
    m  = exp_mask(wa, wb, ls);
    cw = s && acc && (m != '0);
    cr = s && acc && (m == '0);
    ee = prev_rd_v && !cw && !out_en_n && awk;
    ed = prev_rd_d;
    if (cw)
      for (int l = 0; l < LANES; l++)
        if (m[l]) ref_mem[a][l*LW +: LW] = d[l*LW +: LW];
    prev_rd_v = cr;
    if (cr) prev_rd_d = ref_mem[a];
    @(negedge clk);
    check(dout_en == ee, {tag, " drive enable"}, W'(dout_en), W'(ee));
    if (ee) check(dout == ed, {tag, " read data"}, dout, ed);
  endtask

  task automatic wr(input string tag, input int a, input logic [W-1:0] d);
    step(tag, 1'b1, AW'(a), 1'b0, 1'b1, '1, d, 1'b1, 1'b1);
  endtask
  task automatic bwr(input string tag, input int a, input logic [LANES-1:0] ls, input logic [W-1:0] d);
    step(tag, 1'b1, AW'(a), 1'b1, 1'b0, ls, d, 1'b1, 1'b1);
  endtask
  task automatic rd(input string tag, input int a);
    step(tag, 1'b1, AW'(a), 1'b1, 1'b1, '1, '0, 1'b1, 1'b1);
  endtask
  task automatic idle(input string tag);
    step(tag, 1'b0, '0, 1'b1, 1'b1, '1, '0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    check(dout_en == 1'b0, "R12 drive enable during reset", W'(dout_en), '0);
    @(negedge clk);
    rst = 1'b0;
    check(dout_en == 1'b0, "R12 drive enable after reset", W'(dout_en), '0);
    idle("R12");

    // R1: full writes ignore the byte controls
    for (int a = 0; a < DEPTH; a++)
      step("R1", 1'b1, AW'(a), 1'b0, a[0], a[3:0], pat(a), 1'b1, 1'b1);
    for (int a = 0; a < DEPTH; a++) rd("R1", a);
    idle("R1");

    // R2 and R7: every lane mask, back-to-back read and delayed read
    for (int m = 0; m < 16; m++) begin
      bwr("R2", 3, 4'(m), pat(100 + m));
      rd("R7", 3);
      idle("R7");
      rd("R2", 3);
      idle("R2");
    end

    // R3: both write controls high is a read
    step("R3", 1'b1, AW'(4), 1'b1, 1'b1, '0, pat(200), 1'b1, 1'b1);
    rd("R3", 4);
    idle("R3");

    // R4: lane 1 spans bits 17..9
    wr("R4", 10, '0);
    bwr("R4", 10, 4'b1101, '1);
    rd("R4", 10);
    idle("R4");
    check(dout == W'(36'h0_0003_FE00), "R4 lane 1 bit span", dout, W'(36'h0_0003_FE00));

    // R6: output enable pin and write blanking
    wr("R6", 11, pat(300));
    out_en_n = 1'b1;
    rd("R6", 11);
    idle("R6");
    out_en_n = 1'b0;
    #1;
    check(dout_en == 1'b1, "R6 asynchronous enable", W'(dout_en), W'(1));
    check(dout == pat(300), "R6 held data", dout, pat(300));
    rd("R6", 11);
    wr("R6", 12, pat(301));
    idle("R6");

    // R9: deselect ends driving and blocks writes
    rd("R9", 11);
    idle("R9");
    idle("R9");
    step("R9", 1'b0, AW'(12), 1'b0, 1'b1, '1, pat(999), 1'b1, 1'b1);
    rd("R9", 12);
    idle("R9");

    // R8, R10, R11: power down and recovery
    wr("R11", 5, pat(400));
    wr("R11", 6, pat(401));
    wr("R11", 7, pat(402));
    wr("R11", 8, pat(403));
    idle("R11");
    sleep_req = 1'b1;
    step("R8", 1'b1, AW'(5), 1'b1, 1'b1, '1, '0, 1'b1, 1'b1);
    step("R8", 1'b1, AW'(6), 1'b0, 1'b1, '1, pat(500), 1'b1, 1'b1);
    step("R8", 1'b1, AW'(6), 1'b1, 1'b1, '1, '0, 1'b1, 1'b0);
    step("R8", 1'b1, AW'(5), 1'b0, 1'b1, '1, pat(501), 1'b0, 1'b0);
    step("R8", 1'b1, AW'(5), 1'b1, 1'b1, '1, '0, 1'b0, 1'b0);
    step("R8", 1'b0, '0, 1'b1, 1'b1, '1, '0, 1'b0, 1'b0);
    sleep_req = 1'b0;
    step("R10", 1'b1, AW'(7), 1'b0, 1'b1, '1, pat(502), 1'b0, 1'b0);
    step("R10", 1'b1, AW'(7), 1'b0, 1'b1, '1, pat(503), 1'b0, 1'b0);
    step("R10", 1'b1, AW'(7), 1'b0, 1'b1, '1, pat(504), 1'b0, 1'b1);
    step("R10", 1'b1, AW'(8), 1'b0, 1'b1, '1, pat(505), 1'b1, 1'b1);
    idle("R11");
    for (int a = 5; a <= 8; a++) rd("R11", a);
    idle("R11");
    check(ref_mem[8] == pat(505), "R10 first accepted write", ref_mem[8], pat(505));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule